// File: doc/BRIEF.md
# Dual-Edge Capture Timer

This block stamps the edges of an external pulse train, for example a fan tach or a speed-sensor signal, against a free-running 16-bit counter on the system clock. The input is first brought into the clock domain and filtered. Each rising transition then copies the counter into a rise register, and each falling transition copies it into a separate fall register. Software reads both values and derives the period from two successive rise stamps and the high or low time from a rise/fall pair, all from the one input.

Every accepted edge sets a pending flag for its own edge type. An interrupt request is raised when a pending flag is set and its own enable pin is high. If a capture register is overwritten before software has read its previous value, an overrun flag is set. Reads use a small request/response handshake. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is being held and `rsp_ready` is low. A held response keeps its data unchanged until it is consumed. Reading the status word clears all of its flags.

Top module: `edge_stamp_timer`

## Requirements
- R1: The counter is 0 in the first cycle after reset is released, adds one every clock, and wraps from 0xFFFF to 0x0000. A stamp taken across the wrap is the wrapped 16-bit value.
- R2: The input passes a two-stage synchroniser and then a two-sample filter. A level that lasts a single clock cycle is ignored: it changes no capture register and sets no flag.
- R3: When the input rises during a cycle in which the counter holds C, the rise register (read address 0) is loaded with C+3 (mod 2^16) on the fourth rising clock edge after that change.
- R4: A falling input is handled the same way, but loads the fall register (read address 1). Any high or low width of two or more cycles is accepted, and the minimums of four cycles high, four cycles low and eight cycles period are always accepted.
- R5: The pending flag and the interrupt request for an edge are raised on the same fourth clock edge. They are still low on the third edge.
- R6: `irq` is the OR of the rise pending flag gated by `irq_en_rise` and the fall pending flag gated by `irq_en_fall`. A disabled edge still sets its pending flag in the status word.
- R7: The status word is at read address 2, with bit0 = rise pending, bit1 = fall pending, bit2 = rise overrun, bit3 = fall overrun, and all other bits 0. Reading it returns the flags as they were before the read and clears all four flags. A flag being set on the same clock edge as the read stays set.
- R8: A capture into a register whose previous value has not been read sets that register's overrun flag. Reading a capture register marks it as read. A read of that register accepted on the same edge as a new capture returns the old value and does not set overrun.
- R9: A response appears one cycle after its request is accepted. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` is held stable.
- R10: During and right after reset, both capture registers and all flags are 0, `irq` is 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_in | input | 1 | Asynchronous pulse-train input |
| irq_en_rise | input | 1 | Enables the interrupt from rising edges |
| irq_en_fall | input | 1 | Enables the interrupt from falling edges |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be taken |
| req_addr | input | 2 | Read address: 0 rise, 1 fall, 2 status, 3 reads zero |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Read response data |
| irq | output | 1 | Interrupt request |

## Verification
A status read can clear the pending flags on the same clock edge at which a new edge sets one. The bench provokes this by issuing the status read so that it is accepted exactly four edges after it changes the input. It expects the response to show the pre-edge status and a second status read to show the new flag. The same alignment is used for a read of the rise register against a new rise capture, where the old stamp must come back and no overrun may appear. A sweep over high and low widths of two to five cycles also checks the stamp differences against those widths.

// File: rtl/ets_pkg.sv
package ets_pkg;
  typedef enum logic [1:0] {
    REG_RISE = 2'd0,
    REG_FALL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } ets_reg_e;

  localparam int EDGE_N   = 2;
  localparam int IDX_RISE = 0;
  localparam int IDX_FALL = 1;
  localparam int STAT_W   = 2 * EDGE_N;
endpackage

// File: rtl/ets_edge_cond.sv
module ets_edge_cond #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise_hit,
  output logic fall_hit
);
  logic [SYNC_N-1:0] sync_q;
  logic [FILT_N-2:0] hist_q;
  logic [FILT_N-1:0] win;
  logic              lvl_q;

  // the newest synchronised sample joins the older ones in a window
  assign win      = {hist_q, sync_q[SYNC_N-1]};
  assign rise_hit = (&win) & ~lvl_q;
  assign fall_hit = ~(|win) & lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      hist_q <= win[FILT_N-2:0];
      if (rise_hit)      lvl_q <= 1'b1;
      else if (fall_hit) lvl_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ets_cap_slot.sv
module ets_cap_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic [W-1:0] stamp,
  input  logic         rd_cap,
  input  logic         clr,
  output logic [W-1:0] cap_q,
  output logic         pend_q,
  output logic         ovr_q,
  output logic         unread_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      pend_q   <= 1'b0;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
    end else if (hit) begin
      cap_q    <= stamp;
      pend_q   <= 1'b1;
      unread_q <= 1'b1;
      ovr_q    <= (ovr_q & ~clr) | (unread_q & ~rd_cap);
    end else begin
      pend_q   <= pend_q & ~clr;
      ovr_q    <= ovr_q & ~clr;
      unread_q <= unread_q & ~rd_cap;
    end
  end
endmodule

// File: rtl/ets_read_port.sv
module ets_read_port
  import ets_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_addr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [W-1:0]             rsp_data,
  input  logic [EDGE_N-1:0][W-1:0] cap,
  input  logic [STAT_W-1:0]        stat,
  output logic [EDGE_N-1:0]        rd_cap,
  output logic                     stat_clr
);
  logic         accept;
  logic [W-1:0] sel;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;

  always_comb begin
    case (req_addr)
      REG_RISE: sel = cap[IDX_RISE];
      REG_FALL: sel = cap[IDX_FALL];
      REG_STAT: sel = {{(W-STAT_W){1'b0}}, stat};
      default:  sel = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < EDGE_N; i++) begin
      rd_cap[i] = accept && (req_addr == 2'(i));
    end
    stat_clr = accept && (req_addr == REG_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
  import ets_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2,
  parameter int FILT_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic             irq_en_rise,
  input  logic             irq_en_fall,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data,
  output logic             irq
);
  logic [CNT_W-1:0]             cnt_q;
  logic [EDGE_N-1:0]            hit;
  logic [EDGE_N-1:0][CNT_W-1:0] cap_q;
  logic [EDGE_N-1:0]            pend_q;
  logic [EDGE_N-1:0]            ovr_q;
  logic [EDGE_N-1:0]            unread_q;
  logic [EDGE_N-1:0]            rd_cap;
  logic                         stat_clr;
  logic [EDGE_N-1:0]            irq_en;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  ets_edge_cond #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .pin      (cap_in),
    .rise_hit (hit[IDX_RISE]),
    .fall_hit (hit[IDX_FALL])
  );

  for (genvar g = 0; g < EDGE_N; g++) begin : g_slot
    ets_cap_slot #(.W(CNT_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit[g]),
      .stamp    (cnt_q),
      .rd_cap   (rd_cap[g]),
      .clr      (stat_clr),
      .cap_q    (cap_q[g]),
      .pend_q   (pend_q[g]),
      .ovr_q    (ovr_q[g]),
      .unread_q (unread_q[g])
    );
  end

  ets_read_port #(.W(CNT_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .cap       (cap_q),
    .stat      ({ovr_q, pend_q}),
    .rd_cap    (rd_cap),
    .stat_clr  (stat_clr)
  );

  assign irq_en = {irq_en_fall, irq_en_rise};
  assign irq    = |(pend_q & irq_en);
endmodule

// File: rtl/edge_stamp_timer_chk.sv
module edge_stamp_timer_chk #(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [W-1:0]       cnt,
  input logic [1:0]         hit,
  input logic [1:0][W-1:0]  cap,
  input logic [1:0]         pend,
  input logic [1:0]         ovr,
  input logic [1:0]         unread,
  input logic [1:0]         rd_cap,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [W-1:0]       rsp_data
);
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == W'($past(cnt) + 1'b1));

  p_rise_latch_r3: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> cap[0] == $past(cnt));

  p_fall_latch_r4: assert property (@(posedge clk) disable iff (rst)
    hit[1] |=> cap[1] == $past(cnt));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> pend[0]);

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    hit[0] && unread[0] && !rd_cap[0] |=> ovr[0]);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind edge_stamp_timer edge_stamp_timer_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt       (cnt_q),
  .hit       (hit),
  .cap       (cap_q),
  .pend      (pend_q),
  .ovr       (ovr_q),
  .unread    (unread_q),
  .rd_cap    (rd_cap),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/edge_stamp_timer_bench.sv
`timescale 1ns/1ps
module edge_stamp_timer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cap_in;
  logic        irq_en_rise;
  logic        irq_en_fall;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [15:0] rsp_data;
  logic        irq;

  always #5 clk = ~clk;

  edge_stamp_timer u_edge_stamp_timer (
    .clk(clk), .rst(rst), .cap_in(cap_in),
    .irq_en_rise(irq_en_rise), .irq_en_fall(irq_en_fall),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq(irq)
  );

  // bench model of the free-running counter
  logic [15:0] mc;
  always @(posedge clk) mc <= rst ? 16'd0 : mc + 16'd1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
    chk("R9", "response present", rsp_valid, 1);
  endtask

  task automatic drive(input logic v, output logic [15:0] st);
    @(negedge clk);
    cap_in = v;
    st = mc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1900000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d, d0, tr, tf, e0, e1;
    rst = 1'b1; cap_in = 1'b0; irq_en_rise = 1'b0; irq_en_fall = 1'b0;
    req_valid = 1'b0; req_addr = 2'd0; rsp_ready = 1'b1;
    idle(4);
    rst = 1'b0;

    // R10 reset state
    chk("R10", "irq", irq, 0);
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "req_ready", req_ready, 1);
    rd(2'd0, d); chk("R10", "rise reg", d, 0);
    rd(2'd1, d); chk("R10", "fall reg", d, 0);
    rd(2'd2, d); chk("R10", "status", d, 0);

    // sweep of high and low widths
    for (int hw = 2; hw <= 5; hw++) begin
      for (int lw = 2; lw <= 5; lw++) begin
        drive(1'b1, tr);
        idle(hw - 1);
        drive(1'b0, tf);
        idle(lw - 1);
        drive(1'b1, tr);
        idle(6);
        rd(2'd0, d0); chk("R3", "rise stamp", d0, 16'(tr + 16'd3));
        rd(2'd1, d);  chk("R4", "fall stamp", d, 16'(tf + 16'd3));
        chk("R4", "low width from stamps", 16'(d0 - d), lw);
        rd(2'd2, d);  chk("R8", "status after unread overwrite", d, 7);
        drive(1'b0, tf);
        idle(6);
        e0 = 16'(tr + 16'd3);
        e1 = 16'(tf + 16'd3);
        rd(2'd1, d);  chk("R4", "second fall stamp", d, e1);
        rd(2'd2, d);  chk("R7", "status fall only", d, 2);
      end
    end

    // R2 single-cycle glitches
    drive(1'b1, tr); drive(1'b0, tf); idle(8);
    rd(2'd2, d); chk("R2", "high glitch status", d, 0);
    rd(2'd0, d); chk("R2", "high glitch rise reg", d, e0);
    drive(1'b1, tr); idle(8); e0 = 16'(tr + 16'd3);
    rd(2'd0, d); chk("R3", "rise stamp", d, e0);
    rd(2'd2, d); chk("R7", "status rise", d, 1);
    drive(1'b0, tf); drive(1'b1, tr); idle(8);
    rd(2'd2, d); chk("R2", "low glitch status", d, 0);
    rd(2'd1, d); chk("R2", "low glitch fall reg", d, e1);
    drive(1'b0, tf); idle(8); e1 = 16'(tf + 16'd3);
    rd(2'd1, d); chk("R4", "fall stamp", d, e1);
    rd(2'd2, d); chk("R7", "status fall", d, 2);

    // R5 latency and R6 enables
    irq_en_rise = 1'b1; irq_en_fall = 1'b0;
    drive(1'b1, tr); idle(3);
    chk("R5", "irq before fourth edge", irq, 0);
    idle(1);
    chk("R5", "irq after fourth edge", irq, 1);
    rd(2'd2, d); chk("R7", "status rise", d, 1);
    chk("R7", "irq cleared by status read", irq, 0);
    e0 = 16'(tr + 16'd3);
    rd(2'd0, d); chk("R3", "rise stamp", d, e0);
    drive(1'b0, tf); idle(6);
    chk("R6", "fall disabled irq", irq, 0);
    rd(2'd2, d); chk("R6", "disabled fall still flagged", d, 2);
    e1 = 16'(tf + 16'd3);
    rd(2'd1, d); chk("R4", "fall stamp", d, e1);
    irq_en_rise = 1'b0; irq_en_fall = 1'b1;
    drive(1'b1, tr); idle(6);
    chk("R6", "rise disabled irq", irq, 0);
    e0 = 16'(tr + 16'd3);
    rd(2'd0, d); chk("R3", "rise stamp", d, e0);
    rd(2'd2, d); chk("R6", "disabled rise still flagged", d, 1);
    drive(1'b0, tf); idle(3);
    chk("R5", "fall irq before fourth edge", irq, 0);
    idle(1);
    chk("R5", "fall irq after fourth edge", irq, 1);
    e1 = 16'(tf + 16'd3);
    rd(2'd1, d); chk("R4", "fall stamp", d, e1);
    rd(2'd2, d); chk("R7", "status fall", d, 2);
    irq_en_fall = 1'b0;

    // R7 status read on the capture edge
    drive(1'b1, tr); idle(2);
    rd(2'd2, d); chk("R7", "read on set edge returns old", d, 0);
    rd(2'd2, d); chk("R7", "flag set on read edge kept", d, 1);
    e0 = 16'(tr + 16'd3);
    drive(1'b0, tf); idle(6); e1 = 16'(tf + 16'd3);
    rd(2'd1, d); chk("R4", "fall stamp", d, e1);
    rd(2'd2, d); chk("R7", "status fall", d, 2);

    // R8 capture-register read on the capture edge
    drive(1'b1, tr); idle(2);
    rd(2'd0, d); chk("R8", "read on capture edge returns old", d, e0);
    e0 = 16'(tr + 16'd3);
    rd(2'd2, d); chk("R8", "no overrun when read coincides", d, 1);
    rd(2'd0, d); chk("R3", "new rise stamp", d, e0);
    drive(1'b0, tf); idle(6); e1 = 16'(tf + 16'd3);
    rd(2'd1, d); chk("R4", "fall stamp", d, e1);
    rd(2'd2, d); chk("R7", "status fall", d, 2);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 2'd0;
    @(negedge clk);
    chk("R9", "rsp_valid held", rsp_valid, 1);
    chk("R9", "req_ready low while held", req_ready, 0);
    chk("R9", "held data", rsp_data, e0);
    d0 = rsp_data;
    req_addr = 2'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9", "data stable", rsp_data, d0);
      chk("R9", "valid stable", rsp_valid, 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "queued request served", rsp_data, e1);
    @(negedge clk);
    chk("R9", "response consumed", rsp_valid, 0);

    // R1 counter wrap
    while (mc != 16'hFFFC) @(negedge clk);
    drive(1'b1, tr); idle(6);
    rd(2'd0, d); chk("R1", "stamp across wrap", d, 16'h0000);
    drive(1'b0, tf); idle(6);
    rd(2'd1, d); chk("R1", "stamp after wrap", d, 16'(tf + 16'd3));
    rd(2'd2, d); chk("R7", "status both", d, 3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule